// File: doc/BRIEF.md
# Split-Capacitor SAR DAC Switch Controller

This block produces the reference-select controls for the capacitor array of a fully differential 10-bit successive-approximation converter. In that array, each of the top five switched bit positions has its capacitor divided into two equal halves. The block also collects the comparator decisions into the finished output word.

While the sample flag is high, the block holds every control in its precharge pattern. After sampling, the comparator produces ten decisions. Each decision arrives with a one-based step number. The block responds to each decision as follows:

- Steps 1 to 5: one split half on one side is pulled down, and the whole capacitor on the opposite side is raised.
- Steps 6 to 9: only one side is raised.
- Step 10: no control changes. The decision becomes the least significant bit of the word.

The first decision needs no array movement before it, because it resolves directly on the sampled top-plate voltage. For this reason, nine switched bit positions are enough for ten output bits.

Every control is encoded as 1 for the high reference and 0 for the low reference. A decision is registered on the rising clock edge at which `dec_valid_i` is high. Its effect is visible on the outputs from that edge on.

Top module: `sar_split_switch_ctrl`

## Requirements
- R1: While `sample_i` is high at a clock edge, all `swp_o`/`swn_o` bits become 0 (low reference) and all `halfp_o`/`halfn_o` bits become 1 (high reference) at that edge.
- R2: After reset, the controls are in the R1 pattern, `code_o` is 0 and `done_o` is 0.
- R3: For step k in 1..5 the affected bit is i = 10-k. A positive decision (`dec_pos_i`=1) sets `halfp_o[i]`=0 and `swn_o[i]`=1. A negative decision sets `halfn_o[i]`=0 and `swp_o[i]`=1.
- R4: For step k in 6..9 the affected bit is i = 10-k (4 down to 1). A positive decision sets only `swn_o[i]`=1. A negative decision sets only `swp_o[i]`=1. No half control changes.
- R5: Step 10 changes no switch control. Its decision becomes bit 0 of the output word.
- R6: A control set in a step keeps its value until the next sample phase. Half controls only fall and whole controls only rise between sample phases.
- R7: In the cycle after the step-10 edge, `done_o` is high for one cycle and `code_o` holds the new word. Bit 9 of the word is the step-1 decision (1 = positive input), and bit 10-k is the step-k decision. `code_o` stays stable until the next completed conversion.
- R8: A decision strobe is ignored while `sample_i` is high, and also when its step number is 0 or above 10. In those cases no control, `code_o` or `done_o` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sample phase flag |
| dec_valid_i | input | 1 | Comparator decision strobe |
| dec_idx_i | input | 4 | One-based step number of the decision |
| dec_pos_i | input | 1 | Decision: 1 when the positive side exceeds the negative side |
| swp_o | output | 9 | Whole-capacitor controls, positive side, bits 9..1 |
| swn_o | output | 9 | Whole-capacitor controls, negative side, bits 9..1 |
| halfp_o | output | 5 | Split-half controls, positive side, bits 9..5 |
| halfn_o | output | 5 | Split-half controls, negative side, bits 9..5 |
| code_o | output | 10 | Conversion result |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Each switch control is its own flop, so a wrong internal state appears on that control's output right after the offending edge. Examples are a wrongly decoded step, a swapped side, or a missed clear by the sample phase. Each of these shows within one cycle of the decision or sample edge.

An error in collecting the decisions stays hidden until the done pulse, when `code_o` reveals it. Sweeping all 1024 decision patterns exposes every bit position and both polarities of each step.

// File: rtl/sar_split_switch_ctrl.sv
module sar_split_switch_ctrl #(
  parameter int N      = 10,
  parameter int NSPLIT = 5,
  parameter int IW     = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              dec_valid_i,
  input  logic [IW-1:0]     dec_idx_i,
  input  logic              dec_pos_i,
  output logic [N-1:1]      swp_o,
  output logic [N-1:1]      swn_o,
  output logic [N-1:N-NSPLIT] halfp_o,
  output logic [N-1:N-NSPLIT] halfn_o,
  output logic [N-1:0]      code_o,
  output logic              done_o
);
  localparam int LO = N - NSPLIT;

  logic [N-1:1] acc;
  wire take     = dec_valid_i & ~sample_i;
  wire hit_last = take && (dec_idx_i == IW'(N));

  for (genvar i = 1; i < N; i++) begin : g_bit
    wire hit = take && (dec_idx_i == IW'(N - i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        swp_o[i] <= 1'b0;
        swn_o[i] <= 1'b0;
        acc[i]   <= 1'b0;
      end else if (sample_i) begin
        swp_o[i] <= 1'b0;
        swn_o[i] <= 1'b0;
        acc[i]   <= 1'b0;
      end else if (hit) begin
        acc[i] <= dec_pos_i;
        if (dec_pos_i) swn_o[i] <= 1'b1;
        else           swp_o[i] <= 1'b1;
      end
    end

    if (i >= LO) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          halfp_o[i] <= 1'b1;
          halfn_o[i] <= 1'b1;
        end else if (sample_i) begin
          halfp_o[i] <= 1'b1;
          halfn_o[i] <= 1'b1;
        end else if (hit) begin
          if (dec_pos_i) halfp_o[i] <= 1'b0;
          else           halfn_o[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      code_o <= '0;
    end else begin
      done_o <= hit_last;
      if (hit_last) code_o <= {acc, dec_pos_i};
    end
  end
endmodule

module sar_split_switch_chk #(
  parameter int N      = 10,
  parameter int NSPLIT = 5,
  parameter int IW     = $clog2(N + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_i,
  input logic              dec_valid_i,
  input logic [IW-1:0]     dec_idx_i,
  input logic [N-1:1]      swp_o,
  input logic [N-1:1]      swn_o,
  input logic [N-1:N-NSPLIT] halfp_o,
  input logic [N-1:N-NSPLIT] halfn_o,
  input logic [N-1:0]      code_o,
  input logic              done_o
);
  AST_SAMPLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> (swp_o == '0 && swn_o == '0 && &halfp_o && &halfn_o)); // R1
  AST_WHOLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> ((($past(swp_o) & ~swp_o) == '0) && (($past(swn_o) & ~swn_o) == '0))); // R6
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> (((~$past(halfp_o) & halfp_o) == '0) && ((~$past(halfn_o) & halfn_o) == '0))); // R6
  AST_LAST_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && !sample_i && dec_idx_i == IW'(N)) |=>
      ($stable(swp_o) && $stable(swn_o) && $stable(halfp_o) && $stable(halfn_o))); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(dec_valid_i && !sample_i && dec_idx_i == IW'(N))); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(code_o))); // R7
  AST_STEP_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((swp_o & swn_o) == '0)); // R3
endmodule

bind sar_split_switch_ctrl sar_split_switch_chk #(.N(N), .NSPLIT(NSPLIT), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .dec_valid_i(dec_valid_i),
  .dec_idx_i(dec_idx_i), .swp_o(swp_o), .swn_o(swn_o), .halfp_o(halfp_o),
  .halfn_o(halfn_o), .code_o(code_o), .done_o(done_o)
);

// File: tb/test_sar_split_switch_ctrl.sv
module test_sar_split_switch_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, sample_i = 1'b0, dec_valid_i = 1'b0, dec_pos_i = 1'b0;
  logic [3:0] dec_idx_i = '0;
  logic [9:1] swp_o, swn_o;
  logic [9:5] halfp_o, halfn_o;
  logic [9:0] code_o;
  logic done_o;

  logic [9:1] ep, en;
  logic [9:5] ehp, ehn;
  logic [9:0] ecode;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_split_switch_ctrl i_sar_split_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .dec_valid_i(dec_valid_i),
    .dec_idx_i(dec_idx_i), .dec_pos_i(dec_pos_i), .swp_o(swp_o), .swn_o(swn_o),
    .halfp_o(halfp_o), .halfn_o(halfn_o), .code_o(code_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_sw(input string req);
    chk(req, {swp_o, swn_o, halfp_o, halfn_o}, {ep, en, ehp, ehn});
  endtask

  task automatic model_sample();
    ep = '0; en = '0; ehp = '1; ehn = '1;
  endtask

  task automatic do_step(input int k, input logic d);
    dec_valid_i = 1'b1; dec_idx_i = 4'(k); dec_pos_i = d;
    @(negedge clk);
    dec_valid_i = 1'b0;
    if (k >= 1 && k <= 9) begin
      if (d) en[10-k] = 1'b1; else ep[10-k] = 1'b1;
      if (k <= 5) begin
        if (d) ehp[10-k] = 1'b0; else ehn[10-k] = 1'b0;
      end
    end
  endtask

  task automatic do_sample();
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    model_sample();
  endtask

  initial begin
    model_sample();
    ecode = '0;
    repeat (2) @(negedge clk);
    chk("R2 reset controls", {swp_o, swn_o, halfp_o, halfn_o}, {9'h0, 9'h0, 5'h1f, 5'h1f});
    chk("R2 reset code", {code_o, done_o}, 11'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 1024; c++) begin
      logic [9:0] tgt;
      tgt = 10'(c);
      sample_i = 1'b1;
      if (c % 64 == 0) begin
        dec_valid_i = 1'b1; dec_idx_i = 4'd1; dec_pos_i = 1'b1;
      end
      @(negedge clk);
      sample_i = 1'b0; dec_valid_i = 1'b0;
      model_sample();
      chk(c % 64 == 0 ? "R8 strobe during sample ignored" : "R1 sample pattern",
          {swp_o, swn_o, halfp_o, halfn_o}, {ep, en, ehp, ehn});
      for (int k = 1; k <= 10; k++) begin
        do_step(k, tgt[10-k]);
        if (k <= 5)       chk_sw("R3 split step");
        else if (k <= 9)  chk_sw("R4 single-side step");
        else              chk_sw("R5 last step no switching");
        if (k < 10) chk("R7 code stable mid conversion", {code_o, done_o}, {ecode, 1'b0});
        if (c % 64 == 5 && k == 4) begin
          for (int b = 0; b < 16; b++) begin
            if (b == 0 || b > 10) begin
              do_step(b, b[0]);
              chk_sw("R8 bad index ignored");
              chk("R8 bad index no done", {code_o, done_o}, {ecode, 1'b0});
            end
          end
        end
      end
      ecode = tgt;
      chk("R7 done with code", {code_o, done_o}, {ecode, 1'b1});
      @(negedge clk);
      chk("R7 done single cycle", {code_o, done_o}, {ecode, 1'b0});
      chk_sw("R6 controls held");
    end

    do_sample();
    chk_sw("R1 final sample");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule